// File: doc/BRIEF.md
# Half-Bridge Gate Command Interlock with Dead Time

This block sits between two pulse-width command lines and the two gate enables of a half-bridge leg. Both commands first pass through a glitch filter that lets a new level through only after it has been held for a set number of clock cycles. The filtered commands then go to an asymmetric arbiter. Channel A always wins. A request on channel B is kept waiting while A is active, not thrown away. Whenever conduction passes from one channel to the other, the arbiter holds both enables off for a fixed number of cycles.

Because B is only deferred, a system can hold the B command high and drive a single pulse train on A. The two gates then switch in complement, with the dead gap inserted at both edges. A gap that is already longer than the minimum passes through unchanged. A halt input drops both enables in the same cycle.

The filter length and the dead time are parameters counted in clock cycles. As an example, 42 cycles at 100 MHz gives a dead time of about 420 ns. A filter length of 20 cycles at that clock rejects pulses of about 100 ns and passes anything of 350 ns or more.

Top module: `hb_gate_guard`

## Requirements
- R1: `gate_a_o` and `gate_b_o` are never high in the same cycle.
- R2: When channel B is conducting and a filtered A request arrives, `gate_b_o` goes low on the next clock. `gate_a_o` goes high only after both enables have been low for exactly DEAD_CYC cycles.
- R3: While channel A is conducting, the level of `cmd_b_i` has no effect, and `gate_b_o` stays low.
- R4: A B request that is still present when A is released turns on `gate_b_o` after exactly DEAD_CYC cycles with both enables low.
- R5: When both enables have already been low for DEAD_CYC cycles or more, a request turns its enable on one clock after the filtered level changes. No extra dead time is added.
- R6: With `cmd_b_i` held at 1 and a pulse train on `cmd_a_i`, the gates switch in complement, and every gap between them lasts exactly DEAD_CYC cycles.
- R7: A command level that holds for fewer than FILT_CYC samples has no effect on the outputs. A level that holds for FILT_CYC samples or more is passed on. The filtered level changes at the clock edge of the FILT_CYC-th sample, and the gate follows one clock later.
- R8: `rst_n` low forces both enables low at once. Reset is released internally on the second clock edge after `rst_n` rises. After reset the block counts as idle, so the first request needs no dead time.
- R9: `halt_i` high forces both enables low in the same cycle. After `halt_i` falls, no enable turns on until DEAD_CYC clock edges have passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| halt_i | input | 1 | Forces both enables low immediately (1 = halt) |
| cmd_a_i | input | 1 | Synchronised channel A command (priority channel) |
| cmd_b_i | input | 1 | Synchronised channel B command |
| gate_a_o | output | 1 | Gate enable for channel A |
| gate_b_o | output | 1 | Gate enable for channel B |

## Verification
Two functions can fall in the same cycle. The first is an A pre-emption, where the filtered A level rises while B is conducting. The second is the end of a dead-time count, where a deferred B request is about to be granted. Both occur during the complementary run with B held high and A driving a pulse train. They occur again when halt is released while a request is pending. A behavioural model checks, cycle by cycle, which enable wins and how long each measured gap lasts.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_A    = 2'd1,
    ARB_B    = 2'd2,
    ARB_DEAD = 2'd3
  } arb_state_e;

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_A   = 0;
  localparam int unsigned CH_B   = 1;
endpackage

// File: rtl/hbg_glitch_filter.sv
module hbg_glitch_filter #(
  parameter int unsigned FILT_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic lvl_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          lvl_q, lvl_d, lvl_en;
  logic          differ, hit;

  always_comb begin
    differ = raw_i ^ lvl_q;
    hit    = differ && (cnt_q == LAST);
    cnt_d  = (differ && !hit) ? cnt_q + 1'b1 : '0;
    cnt_en = differ || (cnt_q != '0);
    lvl_d  = raw_i;
    lvl_en = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (lvl_en) lvl_q <= lvl_d;
    end
  end

  assign lvl_o = lvl_q;

  // R7
  lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(raw_i)));
endmodule

// File: rtl/hbg_arbiter.sv
module hbg_arbiter
  import hbg_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 42
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_i,
  input  logic req_a_i,
  input  logic req_b_i,
  output logic on_a_o,
  output logic on_b_o
);
  localparam int unsigned DW = $clog2(DEAD_CYC + 1);
  localparam logic [DW-1:0] DLAST = DW'(DEAD_CYC - 1);
  localparam logic [DW-1:0] DFULL = DW'(DEAD_CYC);

  arb_state_e    state_q, state_d;
  logic [DW-1:0] dcnt_q, dcnt_d;
  logic          dcnt_en, state_en, dead_done;

  always_comb begin
    state_d   = state_q;
    dcnt_d    = dcnt_q;
    dead_done = (dcnt_q == DLAST);
    if (halt_i) begin
      state_d = ARB_DEAD;
      dcnt_d  = '0;
    end else begin
      case (state_q)
        ARB_IDLE: begin
          if (req_a_i)      state_d = ARB_A;
          else if (req_b_i) state_d = ARB_B;
        end
        ARB_A: begin
          if (!req_a_i) begin
            state_d = ARB_DEAD;
            dcnt_d  = '0;
          end
        end
        ARB_B: begin
          if (req_a_i || !req_b_i) begin
            state_d = ARB_DEAD;
            dcnt_d  = '0;
          end
        end
        ARB_DEAD: begin
          if (dead_done) begin
            dcnt_d = '0;
            if (req_a_i)      state_d = ARB_A;
            else if (req_b_i) state_d = ARB_B;
            else              state_d = ARB_IDLE;
          end else begin
            dcnt_d = dcnt_q + 1'b1;
          end
        end
        default: state_d = ARB_IDLE;
      endcase
    end
    state_en = (state_d != state_q);
    dcnt_en  = (dcnt_d != dcnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      dcnt_q  <= '0;
    end else begin
      if (state_en) state_q <= state_d;
      if (dcnt_en)  dcnt_q  <= dcnt_d;
    end
  end

  assign on_a_o = (state_q == ARB_A) && !halt_i;
  assign on_b_o = (state_q == ARB_B) && !halt_i;

  // Checker: cycles since either channel conducted, saturating.
  logic [DW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= DFULL;
    else if (halt_i || on_a_o || on_b_o) gap_q <= '0;
    else if (gap_q != DFULL) gap_q <= gap_q + 1'b1;
  end

  // R2
  b_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_b_o && req_a_i) |=> !on_b_o);

  // R3
  a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_a_o && req_a_i) |=> !on_b_o);

  // R4
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(on_a_o) || $rose(on_b_o)) |-> (gap_q == DFULL));

  // R9
  halt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_i) |-> (!on_a_o && !on_b_o));
endmodule

// File: rtl/hb_gate_guard.sv
module hb_gate_guard
  import hbg_pkg::*;
#(
  parameter int unsigned FILT_CYC = 20,
  parameter int unsigned DEAD_CYC = 42
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_i,
  input  logic cmd_a_i,
  input  logic cmd_b_i,
  output logic gate_a_o,
  output logic gate_b_o
);
  logic rs_meta_q, rs_sync_q;
  logic [NUM_CH-1:0] cmd_raw, cmd_flt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_sync_q <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_sync_q <= rs_meta_q;
    end
  end

  assign cmd_raw[CH_A] = cmd_a_i;
  assign cmd_raw[CH_B] = cmd_b_i;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_filt
    hbg_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk   (clk),
      .rst_n (rs_sync_q),
      .raw_i (cmd_raw[ch]),
      .lvl_o (cmd_flt[ch])
    );
  end

  hbg_arbiter #(.DEAD_CYC(DEAD_CYC)) u_arb (
    .clk     (clk),
    .rst_n   (rs_sync_q),
    .halt_i  (halt_i),
    .req_a_i (cmd_flt[CH_A]),
    .req_b_i (cmd_flt[CH_B]),
    .on_a_o  (gate_a_o),
    .on_b_o  (gate_b_o)
  );

  // R1
  gate_excl_chk: assert property (@(posedge clk) disable iff (!rs_sync_q)
    !(gate_a_o && gate_b_o));

  // R8
  reset_off_chk: assert property (@(posedge clk)
    !rs_sync_q |-> (!gate_a_o && !gate_b_o));
endmodule

// File: tb/hb_gate_guard_bench.sv
module hb_gate_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int F = 4;
  localparam int D = 6;

  logic clk = 1'b0, rst_n = 1'b0, halt = 1'b0, ca = 1'b0, cb = 1'b0;
  logic ga, gb;
  int checks = 0, failures = 0;
  string cur_req = "R8";

  hb_gate_guard #(.FILT_CYC(F), .DEAD_CYC(D)) u_hb_gate_guard (
    .clk(clk), .rst_n(rst_n), .halt_i(halt), .cmd_a_i(ca), .cmd_b_i(cb),
    .gate_a_o(ga), .gate_b_o(gb));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference
  int m_lvl [2];
  int m_run [2];
  int m_off, m_hold, pa, pb, raw;
  bit m_a, m_b;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl[0] = 0; m_lvl[1] = 0; m_run[0] = 0; m_run[1] = 0;
      m_a = 0; m_b = 0; m_off = D - 1; m_hold = 2;
    end else if (m_hold > 0) begin
      m_hold--;
    end else begin
      pa = m_lvl[0]; pb = m_lvl[1];
      if (halt) begin
        m_a = 0; m_b = 0; m_off = 0;
      end else if (m_a) begin
        if (pa == 0) begin m_a = 0; m_off = 0; end
      end else if (m_b) begin
        if (pa != 0 || pb == 0) begin m_b = 0; m_off = 0; end
      end else if (m_off >= D - 1) begin
        if (pa != 0) m_a = 1;
        else if (pb != 0) m_b = 1;
      end else begin
        m_off++;
      end
      for (int ch = 0; ch < 2; ch++) begin
        raw = (ch == 0) ? int'(ca) : int'(cb);
        if (raw != m_lvl[ch]) begin
          m_run[ch]++;
          if (m_run[ch] == F) begin m_lvl[ch] = raw; m_run[ch] = 0; end
        end else begin
          m_run[ch] = 0;
        end
      end
    end
  end

  // Gap statistics
  int gmin, gmax, gn, off_len;
  bit seen_on, was_off;
  int cnt_ga, cnt_gb;

  task automatic clear_stats();
    gmin = 1000000; gmax = 0; gn = 0; off_len = 0;
    seen_on = ga || gb; was_off = 0; cnt_ga = 0; cnt_gb = 0;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic a, input logic b, input logic h);
    @(negedge clk);
    check(cur_req, {ga, gb}, {m_a && !halt, m_b && !halt});
    check("R1", int'(ga && gb), 0);
    if (ga || gb) begin
      if (was_off && seen_on) begin
        gn++;
        if (off_len < gmin) gmin = off_len;
        if (off_len > gmax) gmax = off_len;
      end
      was_off = 0; off_len = 0; seen_on = 1;
    end else begin
      off_len++; was_off = 1;
    end
    if (ga) cnt_ga++;
    if (gb) cnt_gb++;
    ca = a; cb = b; halt = h;
  endtask

  task automatic hold(input logic a, input logic b, input logic h, input int n);
    for (int i = 0; i < n; i++) step(a, b, h);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog all actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8", {ga, gb}, 2'b00);
    rst_n = 1'b1;
    clear_stats();
    hold(0, 0, 0, 5);
    hold(1, 0, 0, 8);
    check("R8", int'(ga), 1);
    hold(0, 0, 0, 20);

    // R7: narrow pulses rejected, F-cycle pulse passed with same width
    cur_req = "R7";
    clear_stats();
    for (int k = 0; k < 4; k++) begin
      hold(1, 0, 0, F - 1);
      hold(0, 0, 0, 8);
      hold(0, 1, 0, F - 1);
      hold(0, 0, 0, 8);
    end
    check("R7", cnt_ga + cnt_gb, 0);
    clear_stats();
    hold(1, 0, 0, F);
    hold(0, 0, 0, 20);
    check("R7", cnt_ga, F);

    // R3: B ignored while A conducts
    cur_req = "R3";
    hold(1, 0, 0, 12);
    clear_stats();
    for (int k = 0; k < 6; k++) begin
      hold(1, 1, 0, 5);
      hold(1, 0, 0, 5);
    end
    check("R3", cnt_gb, 0);
    hold(0, 0, 0, 20);

    // R2: A pre-empts B, then A gets on after dead time
    cur_req = "R2";
    hold(0, 1, 0, 15);
    check("R2", int'(gb), 1);
    clear_stats();
    hold(1, 1, 0, 20);
    check("R2", int'(ga), 1);
    check("R2", gmin, D);
    check("R2", gmax, D);

    // R4: deferred B granted after A releases
    cur_req = "R4";
    clear_stats();
    hold(0, 1, 0, 20);
    check("R4", int'(gb), 1);
    check("R4", gmin, D);
    check("R4", gn, 1);

    // R6: complementary operation with B held high
    cur_req = "R6";
    clear_stats();
    for (int k = 0; k < 3; k++) begin
      hold(1, 1, 0, 20);
      hold(0, 1, 0, 20);
    end
    check("R6", gn, 6);
    check("R6", gmin, D);
    check("R6", gmax, D);

    // R5: gap already long enough is not extended
    cur_req = "R5";
    clear_stats();
    hold(0, 0, 0, 30);
    hold(0, 1, 0, 12);
    check("R5", int'(gb), 1);
    check("R5", int'(gmin > D), 1);
    hold(0, 0, 0, 20);

    // R9: halt drops enables at once; dead time after release
    cur_req = "R9";
    hold(1, 0, 0, 12);
    @(negedge clk);
    halt = 1'b1;
    #1;
    check("R9", {ga, gb}, 2'b00);
    hold(1, 0, 1, 5);
    clear_stats();
    hold(1, 0, 0, D);
    check("R9", cnt_ga, 0);
    hold(1, 0, 0, 6);
    check("R9", int'(ga), 1);

    // R8: reset in mid-run, then first request needs no dead time
    cur_req = "R8";
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8", {ga, gb}, 2'b00);
    ca = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    hold(0, 0, 0, 3);
    hold(0, 1, 0, 3 + F);
    check("R8", int'(gb), 1);
    hold(0, 0, 0, 10);

    finish_run();
  end
endmodule